// File: doc/BRIEF.md
# Paged Host Command and Interrupt Register Unit

This block is the register front end that a host processor sees on a packet network controller. The host reaches it through an 8-bit data bus and a 4-bit register offset. The command byte selects one of three register pages, or a reserved fourth page. The command byte can be reached at offset 0 on every page. On the main page, several offsets mean one register when written and a different register when read. Values that the host writes there as configuration can be read back only through the view page.

The block holds the run/stop state and a transmit request that clears itself. It also holds the remote transfer command field, which it decodes into one strobe per operation. It keeps an interrupt status byte with write-one-to-clear bits and an interrupt mask, and it drives a registered interrupt line. The transmit, receive and transfer engines report events as single-cycle pulses. The engines also report when a transmission has ended, when a transfer is still in flight, and when the host has removed a packet from the receive ring. Reads have no side effects: the read data is a combinational function of the offset and the current state.

Top module: `pkt_host_regs`

## Requirements
- R1: After hardware reset, the command byte reads 0x01 (stop set, start clear, main page, no transfer command). Status reads 0x80, the mask reads 0x00, `irq` is 0 and `online` is 0.
- R2: Command bits 7:6 select the page: 00 main, 01 address, 10 view, 11 reserved. Offset 0 reads and writes the command byte on every page. On the reserved page, all other offsets read 0x00 and ignore writes.
- R3: Main-page writes to offsets 4, 12, 13, 14 and 15 store configuration that reads back only on the view page at the same offset. Main-page reads at those offsets return 0x00.
- R4: On the address page, offsets 1 to 15 are fifteen independent read/write byte registers.
- R5: Command bit 2 (transmit request) is set by writing it as 1. Writing it as 0 leaves it unchanged. It clears one cycle after a `tx_end` pulse. A write of 1 in the same cycle as `tx_end` leaves it set. `tx_req` shows its value.
- R6: Command bits 5:3 are the transfer command: 001 asserts `dma_rd`, 010 `dma_wr`, 011 `dma_send`, and 1xx `dma_abort`. With 000, no strobe is asserted.
- R7: While stop (command bit 0) is 1, the unit leaves the online state on the first cycle in which `xfer_busy` is low. It stays online while `xfer_busy` is high.
- R8: A command write with bit 1 = 1 and bit 0 = 0 (a start command) makes `online` 1 from the next cycle.
- R9: Status bits 0 to 6 are set by the matching bit of `ev_pulse`. A main-page write to offset 7 clears each bit written as 1. A set in the same cycle as a clear wins.
- R10: Status bit 7 sets when the unit leaves the online state, and when `ev_pulse[4]` (ring overwrite) arrives. It clears on a start command or a `ring_pop` pulse, and a set in the same cycle wins. Writing 1 to it has no effect.
- R11: Mask bits 0 to 6 are stored from main-page offset 15 writes. Mask bit 7 always reads 0.
- R12: `irq` is registered. In each cycle it equals the OR, over bits 0 to 6, of status AND mask as they stood in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| ev_pulse | input | 7 | Event pulses, bit i sets status bit i |
| tx_end | input | 1 | Transmission completed or aborted |
| xfer_busy | input | 1 | A transmission or reception is still running |
| ring_pop | input | 1 | A packet was removed from the receive ring |
| irq | output | 1 | Registered interrupt request |
| online | output | 1 | Unit is out of the reset state |
| tx_req | output | 1 | Pending transmit request |
| dma_rd | output | 1 | Remote read command active |
| dma_wr | output | 1 | Remote write command active |
| dma_send | output | 1 | Send-packet command active |
| dma_abort | output | 1 | Transfer abort command active |

## Verification
The hardest state to reach is a stop request that arrives while a transfer is still in flight. The stimulus writes stop and then holds `xfer_busy` high for several cycles, expecting `online` to stay high. It then drops `xfer_busy` and expects the exit and the status bit 7 set to appear together. Same-cycle collisions are also driven on purpose: event against clear, overwrite against `ring_pop`, and transmit request against `tx_end`. After these directed parts, a long stretch of mixed random writes, events and pops is compared against a behavioural model on every clock.

// File: rtl/pkt_regs_pkg.sv
package pkt_regs_pkg;
   typedef enum logic [1:0] {
      PG_MAIN = 2'b00,
      PG_ADDR = 2'b01,
      PG_VIEW = 2'b10,
      PG_RSVD = 2'b11
   } page_e;

   localparam int OFS_CMD    = 0;
   localparam int OFS_TXPG   = 4;
   localparam int OFS_STAT   = 7;
   localparam int OFS_RXCFG  = 12;
   localparam int OFS_TXCFG  = 13;
   localparam int OFS_DATCFG = 14;
   localparam int OFS_MASK   = 15;

   localparam int CMD_STOP    = 0;
   localparam int CMD_START   = 1;
   localparam int CMD_TXREQ   = 2;
   localparam int CMD_DMA_LO  = 3;
   localparam int CMD_DMA_W   = 3;
   localparam int CMD_PAGE_LO = 6;

   localparam int STAT_OVW = 4;
endpackage

// File: rtl/pkt_cmd_unit.sv
module pkt_cmd_unit #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cr_we,
   input  logic [DW-1:0] wdata,
   input  logic          tx_end,
   input  logic          xfer_busy,
   output logic [DW-1:0] cr_q,
   output logic          in_rst,
   output logic          start_cmd,
   output logic          rst_entry
);
   import pkt_regs_pkg::*;

   localparam logic [DW-1:0] CR_RESET = DW'(1) << CMD_STOP;

   logic txreq_d;

   assign start_cmd = cr_we & wdata[CMD_START] & ~wdata[CMD_STOP];
   // leave the online state only when no transfer is still running
   assign rst_entry = ~in_rst & cr_q[CMD_STOP] & ~xfer_busy & ~start_cmd;
   assign txreq_d   = (cr_we & wdata[CMD_TXREQ]) | (cr_q[CMD_TXREQ] & ~tx_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr_q   <= CR_RESET;
         in_rst <= 1'b1;
      end else begin
         if (cr_we) cr_q <= wdata;
         cr_q[CMD_TXREQ] <= txreq_d;
         in_rst <= ~start_cmd & (in_rst | rst_entry);
      end
   end
endmodule

// File: rtl/pkt_irq_unit.sv
module pkt_irq_unit #(
   parameter int NEV = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NEV-1:0] ev,
   input  logic           w1c_we,
   input  logic           imr_we,
   input  logic [NEV-1:0] wbits,
   input  logic           rst_set,
   input  logic           rst_clr,
   output logic [NEV:0]   isr_q,
   output logic [NEV-1:0] imr_q,
   output logic           irq
);
   logic rst_flag_q;

   for (genvar gi = 0; gi < NEV; gi++) begin : g_stat
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= ev[gi] | (bit_q & ~(w1c_we & wbits[gi]));
      end
      assign isr_q[gi] = bit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rst_flag_q <= 1'b1;
      else if (rst_set) rst_flag_q <= 1'b1;
      else if (rst_clr) rst_flag_q <= 1'b0;
   end
   assign isr_q[NEV] = rst_flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr_q <= '0;
         irq   <= 1'b0;
      end else begin
         if (imr_we) imr_q <= wbits;
         irq <= |(isr_q[NEV-1:0] & imr_q);
      end
   end
endmodule

// File: rtl/pkt_dma_decode.sv
module pkt_dma_decode (
   input  logic [2:0] dma_f,
   output logic       dma_rd,
   output logic       dma_wr,
   output logic       dma_send,
   output logic       dma_abort
);
   always_comb begin
      dma_rd    = 1'b0;
      dma_wr    = 1'b0;
      dma_send  = 1'b0;
      dma_abort = dma_f[2];
      if (!dma_f[2]) begin
         unique case (dma_f[1:0])
            2'b01:   dma_rd   = 1'b1;
            2'b10:   dma_wr   = 1'b1;
            2'b11:   dma_send = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pkt_cfg_bank.sv
module pkt_cfg_bank
   import pkt_regs_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  page_e         page,
   input  logic [AW-1:0] addr,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] scr_rdata,
   output logic [DW-1:0] cfg_rdata
);
   localparam int NREG = 2 ** AW;
   localparam int NCFG = 4;
   localparam int CFG_OFS [NCFG] = '{OFS_TXPG, OFS_RXCFG, OFS_TXCFG, OFS_DATCFG};

   logic [DW-1:0] scr_q [NREG];
   logic [DW-1:0] cfg_q [NCFG];
   logic main_we, addr_we;

   assign main_we = we & (page == PG_MAIN);
   assign addr_we = we & (page == PG_ADDR) & (addr != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) scr_q[i] <= '0;
      end else if (addr_we) begin
         scr_q[addr] <= wdata;
      end
   end
   assign scr_rdata = scr_q[addr];

   for (genvar gc = 0; gc < NCFG; gc++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cfg_q[gc] <= '0;
         else if (main_we && addr == AW'(CFG_OFS[gc])) cfg_q[gc] <= wdata;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NCFG; i++)
         if (addr == AW'(CFG_OFS[i])) cfg_rdata = cfg_q[i];
   end
endmodule

// File: rtl/pkt_host_regs.sv
module pkt_host_regs #(
   parameter int DW  = 8,
   parameter int AW  = 4,
   parameter int NEV = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  host_addr,
   input  logic [DW-1:0]  host_wdata,
   input  logic           host_wr,
   output logic [DW-1:0]  host_rdata,
   input  logic [NEV-1:0] ev_pulse,
   input  logic           tx_end,
   input  logic           xfer_busy,
   input  logic           ring_pop,
   output logic           irq,
   output logic           online,
   output logic           tx_req,
   output logic           dma_rd,
   output logic           dma_wr,
   output logic           dma_send,
   output logic           dma_abort
);
   import pkt_regs_pkg::*;

   if (DW != 8) begin : g_bad_dw
      $error("pkt_host_regs: DW must be 8");
   end
   if (AW != 4) begin : g_bad_aw
      $error("pkt_host_regs: AW must be 4");
   end
   if (NEV + 1 != DW) begin : g_bad_nev
      $error("pkt_host_regs: NEV must be DW-1");
   end

   logic [DW-1:0]  cr_q;
   logic [NEV:0]   isr_q;
   logic [NEV-1:0] imr_q;
   logic [DW-1:0]  scr_rdata, cfg_rdata;
   logic           in_rst, start_cmd, rst_entry;
   logic           cr_we, w1c_we, imr_we;
   page_e          page;

   assign page   = page_e'(cr_q[CMD_PAGE_LO +: 2]);
   assign cr_we  = host_wr & (host_addr == AW'(OFS_CMD));
   assign w1c_we = host_wr & (page == PG_MAIN) & (host_addr == AW'(OFS_STAT));
   assign imr_we = host_wr & (page == PG_MAIN) & (host_addr == AW'(OFS_MASK));

   pkt_cmd_unit #(.DW(DW)) u_cmd (
      .clk(clk), .rst_n(rst_n), .cr_we(cr_we), .wdata(host_wdata),
      .tx_end(tx_end), .xfer_busy(xfer_busy), .cr_q(cr_q),
      .in_rst(in_rst), .start_cmd(start_cmd), .rst_entry(rst_entry)
   );

   pkt_irq_unit #(.NEV(NEV)) u_irq (
      .clk(clk), .rst_n(rst_n), .ev(ev_pulse), .w1c_we(w1c_we),
      .imr_we(imr_we), .wbits(host_wdata[NEV-1:0]),
      .rst_set(rst_entry | ev_pulse[STAT_OVW]),
      .rst_clr(start_cmd | ring_pop),
      .isr_q(isr_q), .imr_q(imr_q), .irq(irq)
   );

   pkt_dma_decode u_dma (
      .dma_f(cr_q[CMD_DMA_LO +: CMD_DMA_W]), .dma_rd(dma_rd), .dma_wr(dma_wr),
      .dma_send(dma_send), .dma_abort(dma_abort)
   );

   pkt_cfg_bank #(.DW(DW), .AW(AW)) u_bank (
      .clk(clk), .rst_n(rst_n), .page(page), .addr(host_addr),
      .we(host_wr), .wdata(host_wdata),
      .scr_rdata(scr_rdata), .cfg_rdata(cfg_rdata)
   );

   assign online = ~in_rst;
   assign tx_req = cr_q[CMD_TXREQ];

   always_comb begin
      host_rdata = '0;
      if (host_addr == AW'(OFS_CMD)) begin
         host_rdata = cr_q;
      end else begin
         unique case (page)
            PG_MAIN: if (host_addr == AW'(OFS_STAT)) host_rdata = isr_q;
            PG_ADDR: host_rdata = scr_rdata;
            PG_VIEW: host_rdata = (host_addr == AW'(OFS_MASK)) ? {1'b0, imr_q} : cfg_rdata;
            default: host_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pkt_host_regs_chk.sv
module pkt_host_regs_chk #(
   parameter int NEV = 7
) (
   input logic           clk,
   input logic           rst_n,
   input logic [3:0]     host_addr,
   input logic [7:0]     host_wdata,
   input logic           host_wr,
   input logic [NEV-1:0] ev_pulse,
   input logic           tx_end,
   input logic           xfer_busy,
   input logic           irq,
   input logic           online,
   input logic           tx_req,
   input logic           dma_abort,
   input logic           cr_stop,
   input logic [NEV:0]   isr_q,
   input logic [NEV-1:0] imr_q
);
   logic cmd_wr, start_wr;
   assign cmd_wr   = host_wr && (host_addr == 4'd0);
   assign start_wr = cmd_wr && host_wdata[1] && !host_wdata[0];

   AST_TXREQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_end && !(cmd_wr && host_wdata[2])) |=> !tx_req); // R5
   AST_DMA_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && host_wdata[5]) |=> dma_abort); // R6
   AST_STOP_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_stop && !xfer_busy && !start_wr) |=> !online); // R7
   AST_START_ONLINE: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> online); // R8
   AST_EV_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_pulse != '0) |=> ((isr_q[NEV-1:0] & $past(ev_pulse)) == $past(ev_pulse))); // R9
   AST_OVW_RST: assert property (@(posedge clk) disable iff (!rst_n)
      ev_pulse[4] |=> isr_q[NEV]); // R10
   AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(|(isr_q[NEV-1:0] & imr_q))); // R12
endmodule

bind pkt_host_regs pkt_host_regs_chk #(.NEV(NEV)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
   .host_wr(host_wr), .ev_pulse(ev_pulse), .tx_end(tx_end), .xfer_busy(xfer_busy),
   .irq(irq), .online(online), .tx_req(tx_req), .dma_abort(dma_abort),
   .cr_stop(cr_q[0]), .isr_q(isr_q), .imr_q(imr_q)
);

// File: tb/pkt_host_regs_bench.sv
module pkt_host_regs_bench;
   timeunit 1ns;
   timeprecision 1ps;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [3:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic       host_wr = 1'b0;
   logic [6:0] ev_pulse = '0;
   logic       tx_end = 1'b0, xfer_busy = 1'b0, ring_pop = 1'b0;
   logic [7:0] host_rdata;
   logic       irq, online, tx_req, dma_rd, dma_wr, dma_send, dma_abort;

   int checks = 0;
   int errors = 0;

   // behavioural reference state
   logic [7:0] m_cr, m_isr, m_imr, m_tpg, m_rc, m_tc, m_dc;
   logic [7:0] m_scr [16];
   logic       m_inrst, m_irq;

   pkt_host_regs u_pkt_host_regs (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_wr(host_wr), .host_rdata(host_rdata), .ev_pulse(ev_pulse),
      .tx_end(tx_end), .xfer_busy(xfer_busy), .ring_pop(ring_pop), .irq(irq),
      .online(online), .tx_req(tx_req), .dma_rd(dma_rd), .dma_wr(dma_wr),
      .dma_send(dma_send), .dma_abort(dma_abort)
   );

   function automatic logic [7:0] exp_rd(input logic [3:0] a);
      if (a == 4'd0) return m_cr;
      case (m_cr[7:6])
         2'b00: return (a == 4'd7) ? m_isr : 8'h00;
         2'b01: return m_scr[a];
         2'b10: begin
            case (a)
               4'd4:  return m_tpg;
               4'd12: return m_rc;
               4'd13: return m_tc;
               4'd14: return m_dc;
               4'd15: return m_imr;
               default: return 8'h00;
            endcase
         end
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [3:0] exp_dma(input logic [2:0] f);
      if (f[2]) return 4'b0001;
      case (f[1:0])
         2'b01: return 4'b1000;
         2'b10: return 4'b0100;
         2'b11: return 4'b0010;
         default: return 4'b0000;
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check("R3 host_rdata", host_rdata, exp_rd(host_addr));
      check("R12 irq", {7'd0, irq}, {7'd0, m_irq});
      check("R7/R8 online", {7'd0, online}, {7'd0, !m_inrst});
      check("R5 tx_req", {7'd0, tx_req}, {7'd0, m_cr[2]});
      check("R6 dma strobes", {4'd0, dma_rd, dma_wr, dma_send, dma_abort}, {4'd0, exp_dma(m_cr[5:3])});
   endtask

   task automatic model_reset();
      m_cr = 8'h01; m_isr = 8'h80; m_imr = 8'h00;
      m_tpg = 8'h00; m_rc = 8'h00; m_tc = 8'h00; m_dc = 8'h00;
      for (int i = 0; i < 16; i++) m_scr[i] = 8'h00;
      m_inrst = 1'b1; m_irq = 1'b0;
   endtask

   task automatic cyc(input logic [3:0] a, input logic [7:0] wd, input logic wr,
                      input logic [6:0] ev, input logic te, input logic busy, input logic pop);
      logic [7:0] n_cr, n_isr, n_imr, w1c;
      logic wcr, sc, ent, n_inrst, n_irq;
      logic [1:0] pg;
      host_addr = a; host_wdata = wd; host_wr = wr;
      ev_pulse = ev; tx_end = te; xfer_busy = busy; ring_pop = pop;
      pg  = m_cr[7:6];
      wcr = wr && (a == 4'd0);
      sc  = wcr && wd[1] && !wd[0];
      ent = !m_inrst && m_cr[0] && !busy && !sc;
      n_cr = wcr ? wd : m_cr;
      n_cr[2] = (wcr && wd[2]) || (m_cr[2] && !te);
      n_inrst = sc ? 1'b0 : (m_inrst || ent);
      w1c = (wr && pg == 2'b00 && a == 4'd7) ? wd : 8'h00;
      for (int i = 0; i < 7; i++) n_isr[i] = ev[i] || (m_isr[i] && !w1c[i]);
      if (ent || ev[4])    n_isr[7] = 1'b1;
      else if (sc || pop)  n_isr[7] = 1'b0;
      else                 n_isr[7] = m_isr[7];
      n_irq = |(m_isr[6:0] & m_imr[6:0]);
      n_imr = (wr && pg == 2'b00 && a == 4'd15) ? {1'b0, wd[6:0]} : m_imr;
      @(posedge clk);
      if (wr && pg == 2'b00) begin
         if (a == 4'd4)  m_tpg = wd;
         if (a == 4'd12) m_rc = wd;
         if (a == 4'd13) m_tc = wd;
         if (a == 4'd14) m_dc = wd;
      end
      if (wr && pg == 2'b01 && a != 4'd0) m_scr[a] = wd;
      m_cr = n_cr; m_isr = n_isr; m_imr = n_imr; m_inrst = n_inrst; m_irq = n_irq;
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      cyc(a, d, 1'b1, 7'd0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(host_addr, 8'h00, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
      cyc(a, 8'h00, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0);
      check(tag, host_rdata, exp);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare_all();
      // R1 reset values
      rd(4'd0, 8'h01, "R1 command after reset");
      rd(4'd7, 8'h80, "R1 status after reset");
      check("R1 online after reset", {7'd0, online}, 8'h00);
      wr(4'd0, 8'h81);
      rd(4'd15, 8'h00, "R1 mask after reset");
      // R8 start
      wr(4'd0, 8'h02);
      check("R8 online after start", {7'd0, online}, 8'h01);
      rd(4'd7, 8'h00, "R10 status bit 7 cleared by start");
      // R3 aliasing and R11 mask
      wr(4'd15, 8'hFF); wr(4'd12, 8'h1E); wr(4'd13, 8'h05); wr(4'd14, 8'h48); wr(4'd4, 8'h40);
      rd(4'd12, 8'h00, "R3 main-page read of receive config");
      rd(4'd15, 8'h00, "R3 main-page read of mask offset");
      wr(4'd0, 8'h82);
      rd(4'd15, 8'h7F, "R11 mask bit 7 reads 0");
      rd(4'd12, 8'h1E, "R3 view offset 12");
      rd(4'd13, 8'h05, "R3 view offset 13");
      rd(4'd14, 8'h48, "R3 view offset 14");
      rd(4'd4,  8'h40, "R3 view offset 4");
      // R4 address page
      wr(4'd0, 8'h42);
      for (int i = 1; i < 16; i++) wr(4'(i), 8'(i * 17 + 3));
      for (int i = 1; i < 16; i++) rd(4'(i), 8'(i * 17 + 3), "R4 address page byte");
      // R2 reserved page
      wr(4'd0, 8'hC2);
      rd(4'd0, 8'hC2, "R2 command on reserved page");
      wr(4'd5, 8'hAA);
      rd(4'd5, 8'h00, "R2 reserved page reads zero");
      wr(4'd0, 8'h42);
      rd(4'd5, 8'h58, "R2 reserved page write ignored");
      // R9 / R12 events and interrupt
      wr(4'd0, 8'h02);
      cyc(4'd7, 8'h00, 1'b0, 7'h01, 1'b0, 1'b0, 1'b0);
      rd(4'd7, 8'h01, "R9 event sets status");
      check("R12 irq raised", {7'd0, irq}, 8'h01);
      wr(4'd7, 8'h01);
      rd(4'd7, 8'h00, "R9 write one clears");
      idle(1);
      check("R12 irq dropped", {7'd0, irq}, 8'h00);
      wr(4'd15, 8'h02);
      cyc(4'd7, 8'h00, 1'b0, 7'h01, 1'b0, 1'b0, 1'b0);
      idle(2);
      check("R12 masked event no irq", {7'd0, irq}, 8'h00);
      cyc(4'd7, 8'h01, 1'b1, 7'h01, 1'b0, 1'b0, 1'b0);
      rd(4'd7, 8'h01, "R9 set wins over clear");
      wr(4'd7, 8'hFF);
      rd(4'd7, 8'h00, "R9 clear all");
      // R5 transmit request
      wr(4'd0, 8'h06);
      check("R5 tx_req set", {7'd0, tx_req}, 8'h01);
      idle(3);
      cyc(4'd0, 8'h00, 1'b0, 7'd0, 1'b1, 1'b0, 1'b0);
      check("R5 tx_req cleared by tx_end", {7'd0, tx_req}, 8'h00);
      wr(4'd0, 8'h02);
      check("R5 write 0 no effect", {7'd0, tx_req}, 8'h00);
      cyc(4'd0, 8'h06, 1'b1, 7'd0, 1'b1, 1'b0, 1'b0);
      check("R5 write wins over tx_end", {7'd0, tx_req}, 8'h01);
      cyc(4'd0, 8'h00, 1'b0, 7'd0, 1'b1, 1'b0, 1'b0);
      // R6 transfer command decode
      for (int c = 0; c < 8; c++) begin
         wr(4'd0, {2'b00, 3'(c), 3'b010});
         check("R6 decode", {4'd0, dma_rd, dma_wr, dma_send, dma_abort}, {4'd0, exp_dma(3'(c))});
      end
      wr(4'd0, 8'h02);
      // R7 stop while busy
      cyc(4'd0, 8'h01, 1'b1, 7'd0, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < 4; i++) cyc(4'd7, 8'h00, 1'b0, 7'd0, 1'b0, 1'b1, 1'b0);
      check("R7 online held while busy", {7'd0, online}, 8'h01);
      cyc(4'd7, 8'h00, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0);
      check("R7 offline once idle", {7'd0, online}, 8'h00);
      rd(4'd7, 8'h80, "R10 set on reset entry");
      wr(4'd0, 8'h02);
      check("R8 back online", {7'd0, online}, 8'h01);
      rd(4'd7, 8'h00, "R10 cleared by start");
      // R10 overwrite and ring pop
      cyc(4'd7, 8'h00, 1'b0, 7'h10, 1'b0, 1'b0, 1'b0);
      rd(4'd7, 8'h90, "R10 set on overwrite");
      cyc(4'd7, 8'h00, 1'b0, 7'd0, 1'b0, 1'b0, 1'b1);
      rd(4'd7, 8'h10, "R10 cleared by ring pop");
      cyc(4'd7, 8'h00, 1'b0, 7'h10, 1'b0, 1'b0, 1'b1);
      rd(4'd7, 8'h90, "R10 set wins over pop");
      wr(4'd7, 8'h80);
      rd(4'd7, 8'h90, "R10 read-only bit");
      wr(4'd7, 8'h10);
      cyc(4'd7, 8'h00, 1'b0, 7'd0, 1'b0, 1'b0, 1'b1);
      rd(4'd7, 8'h00, "R10 cleared after pop");
      // mixed stimulus, compared every clock
      for (int i = 0; i < 600; i++) begin
         logic [31:0] r;
         r = $urandom;
         cyc(r[3:0], r[11:4], r[12] & r[13],
             (r[16:14] == 3'd0) ? r[23:17] : 7'd0,
             r[24] & r[25], r[26], r[27] & r[28] & r[29]);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule